// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Logic

This block holds the interrupt bookkeeping for a two-channel serial controller. For each channel (channel A is index 0, channel B is index 1) it keeps four flags: receive pending, transmit pending, receive under service and transmit under service. From these it maintains an interrupt-pending byte and an interrupt-vector byte, both readable by software through the controller's register file. It also drives one interrupt line shared by both channels.

The surrounding controller passes in one-cycle event strobes for each channel: byte received, transmit done, break detected, data port read, and the two software commands "reset transmit pending" and "reset highest under service". It also passes in the enable fields held in the controller's write registers. Receive service takes priority over transmit service. A status-high/status-low select picks one of two encodings for the vector byte. Every flag, the pending byte and the vector byte change on the clock edge at which the strobe is sampled.

Top module: `sio_irq_vector`

## Requirements
- R1: After reset, `irq` is 0, `pend_bits` is 0x00, `vec_code` is 0x00 and `brk_stat` is 00.
- R2: A receive event on a channel sets its receive-pending and receive-under-service flags. It sets `pend_bits` bit 5 for channel A or bit 2 for channel B, and loads the receive vector code. Bits 7, 6, 3 and 0 of `pend_bits` are always 0.
- R3: A transmit event sets transmit pending. Only if that channel has no receive under service does it also set transmit under service, set `pend_bits` bit 4 (A) or bit 1 (B) when that channel's `tx_ie` is 1, and load the transmit vector code. Otherwise `pend_bits` and `vec_code` keep their values.
- R4: With `stat_hi`=1 the vector codes are: A receive 0x30, B receive 0x20, A transmit 0x10, B transmit 0x00, none 0x60. With `stat_hi`=0 they are: A receive 0x0C, B receive 0x04, A transmit 0x08, B transmit 0x00, none 0x06.
- R5: A data read clears that channel's receive pending, receive under service and receive pending bit, and loads the "none" code. If transmit is still pending, the transmit action of R3 is then applied again.
- R6: The reset-transmit-pending command clears that channel's transmit pending, transmit under service and transmit pending bit, and loads the "none" code. If receive is still pending, the receive action of R2 is then applied again.
- R7: The reset-highest-under-service command works as follows. If receive is under service, it clears that flag and then, if transmit is pending, applies R3. Otherwise it clears transmit under service. With nothing under service it changes nothing visible.
- R8: `irq` is 1 exactly when, for either channel, one of these holds: `tx_ie`=1 with transmit pending; the channel's 2-bit `rx_mode` field equal to 01 or 10 with receive pending; or `brk_ie`=1 with `brk_stat`=1.
- R9: A break event sets that channel's `brk_stat` bit, which then stays at 1 until reset.
- R10: Events in one cycle are applied in a fixed order. Channel A goes first, then channel B. Within a channel the order is: data read, reset transmit pending, reset highest under service, receive event, transmit event. A later step may overwrite the vector loaded by an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | 2 | Byte received strobe, one bit per channel |
| tx_evt | input | 2 | Transmit done strobe |
| brk_evt | input | 2 | Break detected strobe |
| data_rd | input | 2 | Data port read strobe |
| cmd_clr_tx | input | 2 | Reset transmit pending command strobe |
| cmd_clr_ius | input | 2 | Reset highest under service command strobe |
| stat_hi | input | 1 | Vector encoding select (1 = status high) |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, bits [1:0] channel A, [3:2] channel B |
| brk_ie | input | 2 | Break interrupt enable per channel |
| irq | output | 1 | Shared interrupt request |
| pend_bits | output | 8 | Interrupt pending byte |
| vec_code | output | 8 | Interrupt vector byte |
| brk_stat | output | 2 | Sticky break status per channel |

## Verification
The functions that can collide in one cycle are a channel's receive event and its transmit event, and also a data read arriving together with a new receive event. The bench pulses both strobes on the same clock. It then checks that receive wins the service slot: the receive code appears and no transmit pending bit is set. Collisions across channels are provoked the same way, with a receive on A and a transmit on B. The bench judges them by expecting B's transmit code in the vector byte and both pending bits set.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NCH   = 2;
  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] V_RXA_HI = 8'h30;
  localparam logic [REG_W-1:0] V_RXB_HI = 8'h20;
  localparam logic [REG_W-1:0] V_TXA_HI = 8'h10;
  localparam logic [REG_W-1:0] V_NONE_HI = 8'h60;
  localparam logic [REG_W-1:0] V_RXA_LO = 8'h0C;
  localparam logic [REG_W-1:0] V_RXB_LO = 8'h04;
  localparam logic [REG_W-1:0] V_TXA_LO = 8'h08;
  localparam logic [REG_W-1:0] V_NONE_LO = 8'h06;
  localparam logic [REG_W-1:0] V_TXB    = 8'h00;

  typedef struct packed {
    logic [NCH-1:0]   rxp;
    logic [NCH-1:0]   txp;
    logic [NCH-1:0]   rxs;
    logic [NCH-1:0]   txs;
    logic [REG_W-1:0] pend;
    logic [REG_W-1:0] vec;
  } irq_state_t;

  function automatic int rx_pos(logic ch);
    return ch ? 2 : 5;
  endfunction

  function automatic int tx_pos(logic ch);
    return ch ? 1 : 4;
  endfunction

  function automatic logic [REG_W-1:0] rx_code(logic ch, logic hi);
    if (hi) return ch ? V_RXB_HI : V_RXA_HI;
    return ch ? V_RXB_LO : V_RXA_LO;
  endfunction

  function automatic logic [REG_W-1:0] tx_code(logic ch, logic hi);
    if (ch) return V_TXB;
    return hi ? V_TXA_HI : V_TXA_LO;
  endfunction

  function automatic logic [REG_W-1:0] none_code(logic hi);
    return hi ? V_NONE_HI : V_NONE_LO;
  endfunction

  function automatic irq_state_t do_set_rx(irq_state_t s, logic ch, logic hi);
    irq_state_t r;
    r = s;
    r.rxp[ch] = 1'b1;
    r.rxs[ch] = 1'b1;
    r.pend[rx_pos(ch)] = 1'b1;
    r.vec = rx_code(ch, hi);
    return r;
  endfunction

  function automatic irq_state_t do_set_tx(irq_state_t s, logic ch, logic hi, logic ie);
    irq_state_t r;
    r = s;
    r.txp[ch] = 1'b1;
    if (!r.rxs[ch]) begin
      r.txs[ch] = 1'b1;
      if (ie) r.pend[tx_pos(ch)] = 1'b1;
      r.vec = tx_code(ch, hi);
    end
    return r;
  endfunction

  function automatic irq_state_t do_clr_rx(irq_state_t s, logic ch, logic hi, logic ie);
    irq_state_t r;
    r = s;
    r.rxp[ch] = 1'b0;
    r.rxs[ch] = 1'b0;
    r.pend[rx_pos(ch)] = 1'b0;
    r.vec = none_code(hi);
    if (r.txp[ch]) r = do_set_tx(r, ch, hi, ie);
    return r;
  endfunction

  function automatic irq_state_t do_clr_tx(irq_state_t s, logic ch, logic hi);
    irq_state_t r;
    r = s;
    r.txp[ch] = 1'b0;
    r.txs[ch] = 1'b0;
    r.pend[tx_pos(ch)] = 1'b0;
    r.vec = none_code(hi);
    if (r.rxp[ch]) r = do_set_rx(r, ch, hi);
    return r;
  endfunction

  function automatic irq_state_t do_clr_ius(irq_state_t s, logic ch, logic hi, logic ie);
    irq_state_t r;
    r = s;
    if (r.rxs[ch]) begin
      r.rxs[ch] = 1'b0;
      if (r.txp[ch]) r = do_set_tx(r, ch, hi, ie);
    end else begin
      r.txs[ch] = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/sio_irq_rstsync.sv
module sio_irq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sio_irq_seq.sv
module sio_irq_seq
  import sio_irq_pkg::*;
(
  input  irq_state_t     cur,
  input  logic [NCH-1:0] rx_evt,
  input  logic [NCH-1:0] tx_evt,
  input  logic [NCH-1:0] data_rd,
  input  logic [NCH-1:0] cmd_clr_tx,
  input  logic [NCH-1:0] cmd_clr_ius,
  input  logic           stat_hi,
  input  logic [NCH-1:0] tx_ie,
  output irq_state_t     nxt
);
  always_comb begin
    nxt = cur;
    for (int c = 0; c < NCH; c++) begin
      if (data_rd[c])     nxt = do_clr_rx(nxt, 1'(c), stat_hi, tx_ie[c]);
      if (cmd_clr_tx[c])  nxt = do_clr_tx(nxt, 1'(c), stat_hi);
      if (cmd_clr_ius[c]) nxt = do_clr_ius(nxt, 1'(c), stat_hi, tx_ie[c]);
      if (rx_evt[c])      nxt = do_set_rx(nxt, 1'(c), stat_hi);
      if (tx_evt[c])      nxt = do_set_tx(nxt, 1'(c), stat_hi, tx_ie[c]);
    end
  end
endmodule

// File: rtl/sio_irq_brk.sv
module sio_irq_brk
  import sio_irq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] brk_evt,
  output logic [NCH-1:0] brk_stat
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic flag_d, flag_q, flag_en;

    always_comb begin
      flag_en = brk_evt[c];
      flag_d  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign brk_stat[c] = flag_q;
  end
endmodule

// File: rtl/sio_irq_req.sv
module sio_irq_req
  import sio_irq_pkg::*;
(
  input  logic [NCH-1:0]   rxp,
  input  logic [NCH-1:0]   txp,
  input  logic [NCH-1:0]   brk_stat,
  input  logic [NCH-1:0]   tx_ie,
  input  logic [2*NCH-1:0] rx_mode,
  input  logic [NCH-1:0]   brk_ie,
  output logic             irq
);
  logic [NCH-1:0] chan_req;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] mode;
    logic       rx_on;
    assign mode  = rx_mode[2*c +: 2];
    assign rx_on = (mode == 2'b01) || (mode == 2'b10);
    assign chan_req[c] = (tx_ie[c] & txp[c]) | (rx_on & rxp[c]) | (brk_ie[c] & brk_stat[c]);
  end

  assign irq = |chan_req;
endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   rx_evt,
  input  logic [NCH-1:0]   tx_evt,
  input  logic [NCH-1:0]   brk_evt,
  input  logic [NCH-1:0]   data_rd,
  input  logic [NCH-1:0]   cmd_clr_tx,
  input  logic [NCH-1:0]   cmd_clr_ius,
  input  logic             stat_hi,
  input  logic [NCH-1:0]   tx_ie,
  input  logic [2*NCH-1:0] rx_mode,
  input  logic [NCH-1:0]   brk_ie,
  output logic             irq,
  output logic [REG_W-1:0] pend_bits,
  output logic [REG_W-1:0] vec_code,
  output logic [NCH-1:0]   brk_stat
);
  logic       rst_n_int;
  irq_state_t st_q, st_d;
  logic       st_en;

  sio_irq_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  sio_irq_seq u_seq (
    .cur(st_q), .rx_evt(rx_evt), .tx_evt(tx_evt), .data_rd(data_rd),
    .cmd_clr_tx(cmd_clr_tx), .cmd_clr_ius(cmd_clr_ius),
    .stat_hi(stat_hi), .tx_ie(tx_ie), .nxt(st_d)
  );

  assign st_en = |{rx_evt, tx_evt, data_rd, cmd_clr_tx, cmd_clr_ius};

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  st_q <= '0;
    else if (st_en)  st_q <= st_d;
  end

  sio_irq_brk u_brk (
    .clk(clk), .rst_n(rst_n_int), .brk_evt(brk_evt), .brk_stat(brk_stat)
  );

  sio_irq_req u_req (
    .rxp(st_q.rxp), .txp(st_q.txp), .brk_stat(brk_stat),
    .tx_ie(tx_ie), .rx_mode(rx_mode), .brk_ie(brk_ie), .irq(irq)
  );

  assign pend_bits = st_q.pend;
  assign vec_code  = st_q.vec;
endmodule

// File: rtl/sio_irq_vector_chk.sv
module sio_irq_vector_chk
  import sio_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   rx_evt,
  input logic [NCH-1:0]   tx_evt,
  input logic [NCH-1:0]   brk_evt,
  input logic [NCH-1:0]   data_rd,
  input logic [NCH-1:0]   cmd_clr_tx,
  input logic [NCH-1:0]   cmd_clr_ius,
  input logic             stat_hi,
  input logic [NCH-1:0]   tx_ie,
  input logic [2*NCH-1:0] rx_mode,
  input logic [NCH-1:0]   brk_ie,
  input logic             irq,
  input logic [REG_W-1:0] pend_bits,
  input logic [REG_W-1:0] vec_code,
  input logic [NCH-1:0]   brk_stat
);
  // R4: vector byte only ever holds a defined code
  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_code inside {8'h30, 8'h20, 8'h10, 8'h60, 8'h0C, 8'h04, 8'h08, 8'h00, 8'h06});

  // R2: unused pending bits stay zero
  assert_pend_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_bits & 8'hC9) == 8'h00);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int RB = (c == 0) ? 5 : 2;
    localparam int TB = (c == 0) ? 4 : 1;

    assert_rx_sets_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt[c] |=> pend_bits[RB]);

    assert_read_clears_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd[c] && !rx_evt[c] |=> !pend_bits[RB]);

    assert_cmd_clears_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clr_tx[c] && !tx_evt[c] |=> !pend_bits[TB]);

    assert_brk_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt[c] |=> brk_stat[c]);

    assert_brk_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      brk_stat[c] |=> brk_stat[c]);

    assert_brk_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_stat[c] && brk_ie[c] |-> irq);
  end
endmodule

bind sio_irq_vector sio_irq_vector_chk u_chk (.*);

// File: tb/sio_irq_vector_tb.sv
module sio_irq_vector_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rx_evt, tx_evt, brk_evt, data_rd, cmd_clr_tx, cmd_clr_ius;
  logic       stat_hi;
  logic [1:0] tx_ie, brk_ie;
  logic [3:0] rx_mode;
  logic       irq;
  logic [7:0] pend_bits, vec_code;
  logic [1:0] brk_stat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sio_irq_vector u_dut (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .brk_evt(brk_evt),
    .data_rd(data_rd), .cmd_clr_tx(cmd_clr_tx), .cmd_clr_ius(cmd_clr_ius),
    .stat_hi(stat_hi), .tx_ie(tx_ie), .rx_mode(rx_mode), .brk_ie(brk_ie),
    .irq(irq), .pend_bits(pend_bits), .vec_code(vec_code), .brk_stat(brk_stat)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic clr_evts();
    rx_evt = '0; tx_evt = '0; brk_evt = '0;
    data_rd = '0; cmd_clr_tx = '0; cmd_clr_ius = '0;
  endtask

  // strobes set before the call are held across one rising edge
  task automatic tick();
    @(negedge clk);
    clr_evts();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clr_evts();
    stat_hi = 1'b0; tx_ie = '0; brk_ie = '0; rx_mode = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq",  {7'b0, irq}, 8'h00);
    chk("R1 pend", pend_bits, 8'h00);
    chk("R1 vec",  vec_code, 8'h00);
    chk("R1 brk",  {6'b0, brk_stat}, 8'h00);
  endtask

  task automatic t_receive();
    do_reset();
    rx_mode = 4'b0001;
    rx_evt = 2'b01; tick();
    chk("R2 A rx pend", pend_bits, 8'h20);
    chk("R4 A rx lo vec", vec_code, 8'h0C);
    chk("R8 A rx irq", {7'b0, irq}, 8'h01);
    data_rd = 2'b01; tick();
    chk("R5 read pend", pend_bits, 8'h00);
    chk("R5 read vec", vec_code, 8'h06);
    chk("R8 idle irq", {7'b0, irq}, 8'h00);
    stat_hi = 1'b1;
    rx_evt = 2'b10; tick();
    chk("R2 B rx pend", pend_bits, 8'h04);
    chk("R4 B rx hi vec", vec_code, 8'h20);
    chk("R8 mode00 irq", {7'b0, irq}, 8'h00);
    rx_mode = 4'b1101; #1;
    chk("R8 mode11 irq", {7'b0, irq}, 8'h00);
    rx_mode = 4'b1001; #1;
    chk("R8 mode10 irq", {7'b0, irq}, 8'h01);
    data_rd = 2'b10; tick();
    chk("R4 none hi vec", vec_code, 8'h60);
    chk("R5 B read pend", pend_bits, 8'h00);
  endtask

  task automatic t_transmit();
    do_reset();
    tx_ie = 2'b01;
    tx_evt = 2'b01; tick();
    chk("R3 A tx pend", pend_bits, 8'h10);
    chk("R4 A tx lo vec", vec_code, 8'h08);
    chk("R8 tx irq", {7'b0, irq}, 8'h01);
    stat_hi = 1'b1;
    cmd_clr_tx = 2'b01; tick();
    chk("R6 clr pend", pend_bits, 8'h00);
    chk("R6 clr vec", vec_code, 8'h60);
    chk("R6 clr irq", {7'b0, irq}, 8'h00);
    tx_evt = 2'b10; tick();
    chk("R3 B tx gated pend", pend_bits, 8'h00);
    chk("R4 B tx hi vec", vec_code, 8'h00);
    chk("R8 B tx disabled irq", {7'b0, irq}, 8'h00);
    tx_evt = 2'b01; tick();
    chk("R4 A tx hi vec", vec_code, 8'h10);
  endtask

  task automatic t_precedence();
    do_reset();
    tx_ie = 2'b01; rx_mode = 4'b0001;
    rx_evt = 2'b01; tick();
    tx_evt = 2'b01; tick();
    chk("R3 blocked pend", pend_bits, 8'h20);
    chk("R3 blocked vec", vec_code, 8'h0C);
    cmd_clr_ius = 2'b01; tick();
    chk("R7 ius rx pend", pend_bits, 8'h30);
    chk("R7 ius rx vec", vec_code, 8'h08);
    cmd_clr_ius = 2'b01; tick();
    chk("R7 ius tx vec", vec_code, 8'h08);
    cmd_clr_tx = 2'b01; tick();
    chk("R6 reapply rx pend", pend_bits, 8'h20);
    chk("R6 reapply rx vec", vec_code, 8'h0C);
    data_rd = 2'b01; tick();
    chk("R5 final vec", vec_code, 8'h06);
    chk("R8 final irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_same_cycle();
    do_reset();
    tx_ie = 2'b01;
    rx_evt = 2'b01; tx_evt = 2'b01; tick();
    chk("R10 rx first pend", pend_bits, 8'h20);
    chk("R10 rx first vec", vec_code, 8'h0C);
    data_rd = 2'b01; tick();
    chk("R5 reapply tx pend", pend_bits, 8'h10);
    chk("R5 reapply tx vec", vec_code, 8'h08);
    chk("R8 tx irq", {7'b0, irq}, 8'h01);
    do_reset();
    tx_ie = 2'b11;
    rx_evt = 2'b01; tx_evt = 2'b10; tick();
    chk("R10 cross pend", pend_bits, 8'h22);
    chk("R10 cross vec", vec_code, 8'h00);
    do_reset();
    rx_evt = 2'b01; tick();
    data_rd = 2'b01; rx_evt = 2'b01; tick();
    chk("R10 read+rx pend", pend_bits, 8'h20);
    chk("R10 read+rx vec", vec_code, 8'h0C);
  endtask

  task automatic t_break();
    do_reset();
    brk_evt = 2'b10; tick();
    chk("R9 brk set", {6'b0, brk_stat}, 8'h02);
    chk("R8 brk disabled irq", {7'b0, irq}, 8'h00);
    brk_ie = 2'b10; #1;
    chk("R8 brk irq", {7'b0, irq}, 8'h01);
    brk_ie = 2'b01; #1;
    chk("R8 other brk_ie irq", {7'b0, irq}, 8'h00);
    repeat (3) tick();
    chk("R9 brk sticky", {6'b0, brk_stat}, 8'h02);
  endtask

  task automatic t_ius_idle();
    do_reset();
    cmd_clr_ius = 2'b11; tick();
    chk("R7 idle pend", pend_bits, 8'h00);
    chk("R7 idle vec", vec_code, 8'h00);
    chk("R7 idle irq", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_receive();
    t_transmit();
    t_precedence();
    t_same_cycle();
    t_break();
    t_ius_idle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule